// File: doc/BRIEF.md
# Standby Output Override Controller

This block manages the low-power states of an imaging timing chip. Software writes a two-bit standby level, an output-drive control bit, hold-polarity patterns and a general-purpose output select mask through a small synchronous write port. From these the block derives enables for the analog front end, the timing section and the crystal oscillator. It also decides what every vertical-driver pin and every general-purpose pin shows. Each pin either passes the live timing waveform or is parked at a programmed level, and each general-purpose pin is driven or left floating.

The block also sequences the timing-core reset. The core reset is an active-low register bit that software clears and then sets. After the chip leaves the deepest standby level, the oscillator needs a settle window, which a counter on the always-on reference clock times out. A release request that arrives early is remembered and carried out on the cycle the window closes.

Top module: `stby_ovr_ctrl`

## Requirements
- R1: After reset, vertical outputs are all 0, every general-purpose enable is 0, all three section enables are 1, the core reset output is 0 (asserted) and the settle-done flag is 1.
- R2: The standby level is written at address 0, bits [1:0]: 0 = run, 1 = light, 2 = medium, 3 = deep. The analog enable is 1 only at level 0. The timing-section enable is 1 at levels 0 and 1. The oscillator enable is 0 only at level 3.
- R3: At level 3 the vertical outputs equal the deep-hold pattern (address 3), whatever the drive control bit (address 1, bit 0) holds.
- R4: At levels 1 and 2, and at level 0 with the drive control bit at 0, the vertical outputs equal the shared light/medium hold pattern (address 2). At level 0 with the drive control bit at 1 they follow the timing waveform input.
- R5: A general-purpose pin is enabled only if its bit in the select mask (address 5) is 1. Its value is the live source at level 0 with drive control 1, and otherwise the general-purpose polarity pattern (address 4).
- R6: With the drive control bit at 0, all general-purpose enables are 0 at levels 0, 1 and 2. At level 3 the enables follow the select mask regardless of the drive control bit.
- R7: A write to the core reset register (address 6) with bit 0 = 0 drives the core reset output to 0 on that edge. A write with bit 0 = 1 while settle-done is 1 drives it to 1 on that edge.
- R8: A write that moves the level from 3 to another level clears settle-done. Settle-done then returns to 1 exactly SETTLE_CNT clock edges after the write edge.
- R9: A write of 1 to the core reset register while settle-done is 0 leaves the output at 0. The output rises on the edge where settle-done returns to 1, unless a write of 0 comes first.
- R10: A write of level 3 drives the core reset output to 0, discards any pending release and holds settle-done at 0 while the level stays 3.
- R11: Writes to address 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW | Register write data |
| v_src | input | NV | Live vertical waveforms from the timing core |
| gp_src | input | NG | Live general-purpose values from the timing core |
| v_out | output | NV | Vertical-driver pin values |
| gp_out | output | NG | General-purpose pin values |
| gp_oe | output | NG | General-purpose pin drive enables (0 = high impedance) |
| ana_en | output | 1 | Analog front-end power enable |
| tg_en | output | 1 | Timing-section power enable |
| osc_en | output | 1 | Crystal oscillator enable |
| core_rst_n | output | 1 | Active-low timing-core reset |
| settle_done | output | 1 | Oscillator settle window has expired |

## Verification
The bench builds the block with eight vertical pins, four general-purpose pins and an 8-bit data port, and shrinks SETTLE_CNT to 40. The short window lets the run reach the exact settle-done edge and the delayed release of a premature core-reset request several times. It also leaves time for a few hundred random writes that mix all four levels with both states of the drive control bit.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [1:0] {
        LVL_RUN   = 2'd0,
        LVL_LIGHT = 2'd1,
        LVL_MED   = 2'd2,
        LVL_DEEP  = 2'd3
    } stby_lvl_e;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_POL12 = 3'd2;
    localparam logic [ADDR_W-1:0] A_POL3  = 3'd3;
    localparam logic [ADDR_W-1:0] A_GPPOL = 3'd4;
    localparam logic [ADDR_W-1:0] A_GPSEL = 3'd5;
    localparam logic [ADDR_W-1:0] A_CRST  = 3'd6;

endpackage

// File: rtl/stby_regs.sv
module stby_regs
    import stby_pkg::*;
#(
    parameter int unsigned NV = 8,
    parameter int unsigned NG = 4,
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output stby_lvl_e         lvl,
    output logic              outctl,
    output logic [NV-1:0]     pol12,
    output logic [NV-1:0]     pol3,
    output logic [NG-1:0]     gppol,
    output logic [NG-1:0]     gpsel,
    output logic              crst_wr,
    output logic              crst_bit,
    output logic              leave3,
    output logic              enter3
);

    typedef struct packed {
        stby_lvl_e     lvl;
        logic          outctl;
        logic [NV-1:0] pol12;
        logic [NV-1:0] pol3;
        logic [NG-1:0] gppol;
        logic [NG-1:0] gpsel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        crst_wr  = 1'b0;
        crst_bit = wr_data[0];
        leave3   = 1'b0;
        enter3   = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_MODE: begin
                    r_d.lvl = stby_lvl_e'(wr_data[1:0]);
                    enter3  = (wr_data[1:0] == 2'd3);
                    leave3  = (r_q.lvl == LVL_DEEP) && (wr_data[1:0] != 2'd3);
                end
                A_CTRL:  r_d.outctl = wr_data[0];
                A_POL12: r_d.pol12  = wr_data[NV-1:0];
                A_POL3:  r_d.pol3   = wr_data[NV-1:0];
                A_GPPOL: r_d.gppol  = wr_data[NG-1:0];
                A_GPSEL: r_d.gpsel  = wr_data[NG-1:0];
                A_CRST:  crst_wr    = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lvl    = r_q.lvl;
    assign outctl = r_q.outctl;
    assign pol12  = r_q.pol12;
    assign pol3   = r_q.pol3;
    assign gppol  = r_q.gppol;
    assign gpsel  = r_q.gpsel;

endmodule

// File: rtl/stby_rst_seq.sv
module stby_rst_seq #(
    parameter int unsigned SETTLE_CNT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_deep,
    input  logic leave3,
    input  logic enter3,
    input  logic crst_wr,
    input  logic crst_bit,
    output logic core_rst_n,
    output logic settle_done
);

    localparam int unsigned CW = $clog2(SETTLE_CNT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic          pend;
        logic          rstb;
    } seq_t;

    seq_t s_d, s_q;
    logic deep_next;

    always_comb begin
        s_d       = s_q;
        deep_next = enter3 || (in_deep && !leave3);

        // settle counter
        if (leave3)              s_d.cnt = CW'(SETTLE_CNT);
        else if (s_q.cnt != '0)  s_d.cnt = s_q.cnt - 1'b1;
        s_d.busy = (s_d.cnt != '0) || deep_next;

        // core reset sequencing
        if (enter3) begin
            s_d.rstb = 1'b0;
            s_d.pend = 1'b0;
        end else if (crst_wr) begin
            if (!crst_bit) begin
                s_d.rstb = 1'b0;
                s_d.pend = 1'b0;
            end else if (!s_q.rstb) begin
                if (!s_d.busy) s_d.rstb = 1'b1;
                else           s_d.pend = 1'b1;
            end
        end else if (s_q.pend && !s_d.busy) begin
            s_d.rstb = 1'b1;
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign core_rst_n  = s_q.rstb;
    assign settle_done = !s_q.busy;

endmodule

// File: rtl/stby_out_sel.sv
module stby_out_sel
    import stby_pkg::*;
#(
    parameter int unsigned NV = 8,
    parameter int unsigned NG = 4
) (
    input  stby_lvl_e     lvl,
    input  logic          outctl,
    input  logic [NV-1:0] pol12,
    input  logic [NV-1:0] pol3,
    input  logic [NG-1:0] gppol,
    input  logic [NG-1:0] gpsel,
    input  logic [NV-1:0] v_src,
    input  logic [NG-1:0] gp_src,
    output logic [NV-1:0] v_out,
    output logic [NG-1:0] gp_out,
    output logic [NG-1:0] gp_oe,
    output logic          ana_en,
    output logic          tg_en,
    output logic          osc_en
);

    logic is_deep, live, gp_drive;

    always_comb begin
        is_deep  = (lvl == LVL_DEEP);
        live     = (lvl == LVL_RUN) && outctl;
        gp_drive = is_deep || outctl;
        ana_en   = (lvl == LVL_RUN);
        tg_en    = (lvl == LVL_RUN) || (lvl == LVL_LIGHT);
        osc_en   = !is_deep;
    end

    for (genvar i = 0; i < NV; i++) begin : g_vert
        always_comb begin
            if (is_deep)   v_out[i] = pol3[i];
            else if (live) v_out[i] = v_src[i];
            else           v_out[i] = pol12[i];
        end
    end

    for (genvar j = 0; j < NG; j++) begin : g_gp
        always_comb begin
            gp_out[j] = live ? gp_src[j] : gppol[j];
            gp_oe[j]  = gpsel[j] && gp_drive;
        end
    end

endmodule

// File: rtl/stby_ovr_ctrl.sv
module stby_ovr_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned NV         = 8,
    parameter int unsigned NG         = 4,
    parameter int unsigned DW         = 8,
    parameter int unsigned SETTLE_CNT = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [NV-1:0]     v_src,
    input  logic [NG-1:0]     gp_src,
    output logic [NV-1:0]     v_out,
    output logic [NG-1:0]     gp_out,
    output logic [NG-1:0]     gp_oe,
    output logic              ana_en,
    output logic              tg_en,
    output logic              osc_en,
    output logic              core_rst_n,
    output logic              settle_done
);

    stby_lvl_e     lvl;
    logic          outctl;
    logic [NV-1:0] pol12, pol3;
    logic [NG-1:0] gppol, gpsel;
    logic          crst_wr, crst_bit, leave3, enter3;

    stby_regs #(.NV(NV), .NG(NG), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .lvl      (lvl),
        .outctl   (outctl),
        .pol12    (pol12),
        .pol3     (pol3),
        .gppol    (gppol),
        .gpsel    (gpsel),
        .crst_wr  (crst_wr),
        .crst_bit (crst_bit),
        .leave3   (leave3),
        .enter3   (enter3)
    );

    stby_rst_seq #(.SETTLE_CNT(SETTLE_CNT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_deep     (lvl == LVL_DEEP),
        .leave3      (leave3),
        .enter3      (enter3),
        .crst_wr     (crst_wr),
        .crst_bit    (crst_bit),
        .core_rst_n  (core_rst_n),
        .settle_done (settle_done)
    );

    stby_out_sel #(.NV(NV), .NG(NG)) u_sel (
        .lvl    (lvl),
        .outctl (outctl),
        .pol12  (pol12),
        .pol3   (pol3),
        .gppol  (gppol),
        .gpsel  (gpsel),
        .v_src  (v_src),
        .gp_src (gp_src),
        .v_out  (v_out),
        .gp_out (gp_out),
        .gp_oe  (gp_oe),
        .ana_en (ana_en),
        .tg_en  (tg_en),
        .osc_en (osc_en)
    );

endmodule

// File: rtl/stby_ovr_chk.sv
module stby_ovr_chk
    import stby_pkg::*;
#(
    parameter int unsigned NV = 8,
    parameter int unsigned NG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_low,
    input logic [NV-1:0]     v_out,
    input logic [NV-1:0]     pol12,
    input logic [NV-1:0]     pol3,
    input logic [NG-1:0]     gp_oe,
    input logic [NG-1:0]     gpsel,
    input logic              outctl,
    input logic              osc_en,
    input logic              core_rst_n,
    input logic              settle_done
);

    // R10
    deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_MODE && wr_low == 2'b11 |=> !osc_en && !settle_done && !core_rst_n);

    // R3
    deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> v_out == pol3);

    // R4
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en && !outctl |-> v_out == pol12);

    // R5
    gp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_oe & ~gpsel) == '0);

    // R6
    gp_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en && !outctl |-> gp_oe == '0);

    // R9
    release_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> settle_done);

    // R7
    reset_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_CRST && !wr_low[0] |=> !core_rst_n);

endmodule

bind stby_ovr_ctrl stby_ovr_chk #(.NV(NV), .NG(NG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_low      (wr_data[1:0]),
    .v_out       (v_out),
    .pol12       (pol12),
    .pol3        (pol3),
    .gp_oe       (gp_oe),
    .gpsel       (gpsel),
    .outctl      (outctl),
    .osc_en      (osc_en),
    .core_rst_n  (core_rst_n),
    .settle_done (settle_done)
);

// File: tb/tb_stby_ovr_ctrl.sv
module tb_stby_ovr_ctrl;

    localparam int CLK_P = 10;
    localparam int NV = 8;
    localparam int NG = 4;
    localparam int DW = 8;
    localparam int SC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NV-1:0] v_src = '0;
    logic [NG-1:0] gp_src = '0;
    logic [NV-1:0] v_out;
    logic [NG-1:0] gp_out, gp_oe;
    logic          ana_en, tg_en, osc_en, core_rst_n, settle_done;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side register shadow
    logic [1:0]    m_lvl = '0;
    logic          m_oc = 1'b0;
    logic [NV-1:0] m_p12 = '0, m_p3 = '0;
    logic [NG-1:0] m_gpp = '0, m_gps = '0;

    stby_ovr_ctrl #(.NV(NV), .NG(NG), .DW(DW), .SETTLE_CNT(SC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .v_src(v_src), .gp_src(gp_src), .v_out(v_out), .gp_out(gp_out), .gp_oe(gp_oe),
        .ana_en(ana_en), .tg_en(tg_en), .osc_en(osc_en),
        .core_rst_n(core_rst_n), .settle_done(settle_done)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: m_lvl = d[1:0];
            3'd1: m_oc  = d[0];
            3'd2: m_p12 = d[NV-1:0];
            3'd3: m_p3  = d[NV-1:0];
            3'd4: m_gpp = d[NG-1:0];
            3'd5: m_gps = d[NG-1:0];
            default: ;
        endcase
    endtask

    function automatic logic [NV-1:0] exp_v(input logic [NV-1:0] src);
        if (m_lvl == 2'd3)              return m_p3;
        if (m_lvl == 2'd0 && m_oc)      return src;
        return m_p12;
    endfunction

    function automatic logic [NG-1:0] exp_oe();
        if (m_lvl == 2'd3) return m_gps;
        if (!m_oc)         return '0;
        return m_gps;
    endfunction

    function automatic logic [NG-1:0] exp_gp(input logic [NG-1:0] src);
        return (m_lvl == 2'd0 && m_oc) ? src : m_gpp;
    endfunction

    task automatic check_pins(input string tag);
        check({tag, " R3/R4 v_out"}, 32'(v_out), 32'(exp_v(v_src)));
        check({tag, " R5/R6 gp_oe"}, 32'(gp_oe), 32'(exp_oe()));
        check({tag, " R5 gp_out"}, 32'(gp_out), 32'(exp_gp(gp_src)));
        check({tag, " R2 enables"}, {29'd0, ana_en, tg_en, osc_en},
              {29'd0, m_lvl == 2'd0, m_lvl < 2'd2, m_lvl != 2'd3});
    endtask

    task automatic settle_walk(input string tag, input logic exp_rel);
        repeat (SC - 1) @(negedge clk);
        check({tag, " R8 done still low"}, 32'(settle_done), 32'd0);
        check({tag, " R9 reset held"}, 32'(core_rst_n), 32'd0);
        @(negedge clk);
        check({tag, " R8 done rises"}, 32'(settle_done), 32'd1);
        check({tag, " R9 release"}, 32'(core_rst_n), 32'(exp_rel));
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 v_out", 32'(v_out), 32'd0);
        check("R1 gp_oe", 32'(gp_oe), 32'd0);
        check("R1 enables", {29'd0, ana_en, tg_en, osc_en}, 32'd7);
        check("R1 core_rst_n", 32'(core_rst_n), 32'd0);
        check("R1 settle_done", 32'(settle_done), 32'd1);

        // R7 direct release and drop
        wr(3'd6, 8'h01);
        check("R7 release", 32'(core_rst_n), 32'd1);
        wr(3'd6, 8'h00);
        check("R7 drop", 32'(core_rst_n), 32'd0);
        wr(3'd6, 8'h01);
        check("R7 release again", 32'(core_rst_n), 32'd1);

        // R10 deep entry
        wr(3'd3, 8'hA5);
        wr(3'd2, 8'h3C);
        wr(3'd0, 8'h03);
        check("R10 core reset forced", 32'(core_rst_n), 32'd0);
        check("R10 settle low", 32'(settle_done), 32'd0);
        check_pins("deep");

        // R9 premature release held then applied
        wr(3'd6, 8'h01);
        check("R9 held in deep", 32'(core_rst_n), 32'd0);
        wr(3'd0, 8'h00);
        check("R8 done cleared", 32'(settle_done), 32'd0);
        settle_walk("pend", 1'b1);

        // R8 without pending request
        wr(3'd0, 8'h03);
        wr(3'd0, 8'h01);
        settle_walk("nopend", 1'b0);
        wr(3'd6, 8'h01);
        check("R7 release after settle", 32'(core_rst_n), 32'd1);

        // R9 pending cancelled by write 0
        wr(3'd0, 8'h03);
        wr(3'd6, 8'h01);
        wr(3'd0, 8'h02);
        wr(3'd6, 8'h00);
        repeat (SC + 2) @(negedge clk);
        check("R9 cancelled stays low", 32'(core_rst_n), 32'd0);

        // R6 priorities, directed
        wr(3'd5, 8'h0F);
        wr(3'd4, 8'h09);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h01);
        check_pins("light oc0");
        check("R6 float", 32'(gp_oe), 32'd0);
        wr(3'd0, 8'h03);
        check("R6 deep drives", 32'(gp_oe), 32'hF);
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h00);
        v_src = 8'h5A; gp_src = 4'h6;
        #1;
        check_pins("run live");

        // R11 unmapped write
        wr(3'd7, 8'hFF);
        check_pins("R11 unmapped");
        check("R11 core_rst_n", 32'(core_rst_n), 32'd0);

        // constrained random traffic
        for (int k = 0; k < 300; k++) begin
            logic [2:0] a;
            a = 3'($urandom_range(0, 5));
            v_src  = NV'($urandom);
            gp_src = NG'($urandom);
            wr(a, DW'($urandom));
            check_pins("rand");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule